// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt priority state of one hardware thread at one exception level. A presenter delivers priority notifications over a valid/ready stream; each one marks a bit in an eight-entry pending vector. The block continuously finds the most favoured pending priority, where a lower number is more favoured, and compares it with a current priority set by software. While the pending priority is strictly more favoured, the interrupt line to the CPU is high and the exception bit of the status byte is set.

Software reaches the state through a register window of four aligned pages. Two address bits choose a privilege view: physical, hypervisor, operating system or user. Each view carries its own write rights. A separate acknowledge strobe performs the interrupt-accept load in one atomic step. It returns the status and the new current priority, raises the current priority to the serviced level and retires that pending bit.

Back-pressure on the notification stream: a notification is taken in any cycle where `notif_valid` and `notif_ready` are both high. `notif_ready` is low exactly in the cycles where `ack_rd` is high. The presenter holds `notif_valid` and `notif_prio` steady until the transfer is taken.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset the pending vector is 0, the current priority is 0x00, `irq_out` is low and the best-priority register reads 0xFF.
- R2: A notification taken with priority 0 to 6 sets the pending bit of that priority, and the bit is visible from the next cycle.
- R3: The best-priority register holds the lowest-numbered set pending bit, or 0xFF when no bit is set.
- R4: From the cycle after any change, `irq_out` and status bit 7 are high if and only if best priority < current priority (unsigned 8-bit).
- R5: A notification of priority 7 is taken, but it leaves the pending vector unchanged.
- R6: An acknowledge while `irq_out` is high returns {status, best priority} on `ack_data` in that cycle. On the next edge the current priority becomes the best priority and that pending bit clears.
- R7: An acknowledge while `irq_out` is low returns {status, current priority} and changes no state.
- R8: The view is `sw_addr[PAGE_SHIFT+1:PAGE_SHIFT]`, with 0 physical, 1 hypervisor, 2 OS and 3 user. The register offset is `sw_addr[1:0]`. In the physical and hypervisor views, a write to offset 0 loads the current priority and a write to offset 1 replaces the pending vector. A notification taken in the same cycle is merged on top of the new vector.
- R9: In the OS view only offset 0 is writable, and only the values 0 to 6 or 0xFF are accepted. Any other write is ignored.
- R10: Every write through the user view is ignored.
- R11: `notif_ready` is low while `ack_rd` is high, and a write made in an acknowledge cycle is ignored.
- R12: `sw_rdata` returns the register at the offset in every view: 0 is the current priority, 1 the pending vector, 2 the best priority and 3 the status byte with the exception flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notif_valid | input | 1 | Notification present |
| notif_ready | output | 1 | Notification can be taken |
| notif_prio | input | 3 | Priority of the notification |
| sw_wr | input | 1 | Window write strobe |
| sw_addr | input | 14 | Window address (view and offset) |
| sw_wdata | input | 8 | Window write data |
| sw_rdata | output | 8 | Window read data at `sw_addr` |
| ack_rd | input | 1 | Acknowledge load strobe |
| ack_data | output | 16 | {status, current priority after acknowledge} |
| irq_out | output | 1 | Interrupt line to the CPU |

## Verification
The bench goes after the priority boundaries. An equal best and current priority must keep the line low; a design using less-or-equal would interrupt spuriously. An empty vector must read 0xFF rather than 0 or 7, or the line would fire with nothing pending. It also tests acknowledges with the line low, where a faulty design would overwrite the current priority. Other targets are notifications arriving during an acknowledge, which would be lost or merged wrongly, and the reserved priority 7, which a faulty design would latch. OS-view writes of 7 and of the pending vector, and all user-view writes, must leave state untouched, while a behavioural model compared each clock catches any stale interrupt line after a priority change.

// File: rtl/thread_irq_pkg.sv
package thread_irq_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] NONE_PRIO = 8'hFF;

  typedef enum logic [1:0] {
    VIEW_PHYS = 2'd0,
    VIEW_HYP  = 2'd1,
    VIEW_OS   = 2'd2,
    VIEW_USER = 2'd3
  } view_e;

  localparam logic [1:0] OFS_CUR  = 2'd0;
  localparam logic [1:0] OFS_PEND = 2'd1;
  localparam logic [1:0] OFS_BEST = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;
endpackage

// File: rtl/thread_irq_prio_enc.sv
module thread_irq_prio_enc
  import thread_irq_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic [NPRIO-1:0] pend,
  output logic [REG_W-1:0] best
);
  // lowest set index wins; scan from the top so the last hit is the smallest
  always_comb begin
    best = NONE_PRIO;
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (pend[i]) best = REG_W'(i);
    end
  end
endmodule

// File: rtl/thread_irq_pend_buf.sv
module thread_irq_pend_buf #(
  parameter int NPRIO = 8,
  localparam int PRIO_W = $clog2(NPRIO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [PRIO_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [PRIO_W-1:0] clr_idx,
  input  logic              load_en,
  input  logic [NPRIO-1:0]  load_val,
  output logic [NPRIO-1:0]  pend_q,
  output logic [NPRIO-1:0]  pend_d
);
  for (genvar g = 0; g < NPRIO; g++) begin : g_bit
    logic base;
    assign base = load_en ? load_val[g] : pend_q[g];
    assign pend_d[g] = clr_en ? (pend_q[g] && (clr_idx != PRIO_W'(g)))
                              : (base || (set_en && (set_idx == PRIO_W'(g))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/thread_irq_view_dec.sv
module thread_irq_view_dec
  import thread_irq_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic             wr,
  input  logic             blocked,
  input  view_e            view,
  input  logic [1:0]       ofs,
  input  logic [REG_W-1:0] wdata,
  output logic             cur_we,
  output logic             pend_we
);
  localparam logic [REG_W-1:0] FIRST_RSVD = REG_W'(NPRIO - 1);

  always_comb begin
    cur_we  = 1'b0;
    pend_we = 1'b0;
    if (wr && !blocked) begin
      case (view)
        VIEW_PHYS, VIEW_HYP: begin
          cur_we  = (ofs == OFS_CUR);
          pend_we = (ofs == OFS_PEND);
        end
        VIEW_OS: begin
          cur_we = (ofs == OFS_CUR) && ((wdata < FIRST_RSVD) || (wdata == NONE_PRIO));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx
  import thread_irq_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int PAGE_SHIFT = 12,
  localparam int ADDR_W = PAGE_SHIFT + 2,
  localparam int PRIO_W = $clog2(NPRIO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              notif_valid,
  output logic              notif_ready,
  input  logic [PRIO_W-1:0] notif_prio,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata,
  input  logic              ack_rd,
  output logic [2*REG_W-1:0] ack_data,
  output logic              irq_out
);
  localparam logic [PRIO_W-1:0] RSVD_PRIO = PRIO_W'(NPRIO - 1);

  logic [NPRIO-1:0] pend_q, pend_d;
  logic [REG_W-1:0] cur_q, cur_d, best_q, best_d, stat_q;
  logic             exc_q, exc_d;
  logic             ack_take, notif_take, cur_we, pend_we;
  view_e            view;
  logic [1:0]       ofs;

  assign view        = view_e'(sw_addr[PAGE_SHIFT+1:PAGE_SHIFT]);
  assign ofs         = sw_addr[1:0];
  assign notif_ready = !ack_rd;
  assign notif_take  = notif_valid && notif_ready && (notif_prio != RSVD_PRIO);
  assign ack_take    = ack_rd && exc_q;

  thread_irq_view_dec #(.NPRIO(NPRIO)) u_dec (
    .wr(sw_wr), .blocked(ack_rd), .view(view), .ofs(ofs), .wdata(sw_wdata),
    .cur_we(cur_we), .pend_we(pend_we)
  );

  thread_irq_pend_buf #(.NPRIO(NPRIO)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(notif_take), .set_idx(notif_prio),
    .clr_en(ack_take), .clr_idx(best_q[PRIO_W-1:0]),
    .load_en(pend_we), .load_val(sw_wdata[NPRIO-1:0]),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  thread_irq_prio_enc #(.NPRIO(NPRIO)) u_enc_now  (.pend(pend_q), .best(best_q));
  thread_irq_prio_enc #(.NPRIO(NPRIO)) u_enc_next (.pend(pend_d), .best(best_d));

  always_comb begin
    cur_d = cur_q;
    if (ack_take)    cur_d = best_q;
    else if (cur_we) cur_d = sw_wdata;
  end

  assign exc_d = (best_d < cur_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      exc_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      exc_q <= exc_d;
    end
  end

  assign irq_out  = exc_q;
  assign stat_q   = {exc_q, {(REG_W-1){1'b0}}};
  assign ack_data = {stat_q, (ack_take ? best_q : cur_q)};

  always_comb begin
    case (ofs)
      OFS_CUR:  sw_rdata = cur_q;
      OFS_PEND: sw_rdata = REG_W'(pend_q);
      OFS_BEST: sw_rdata = best_q;
      default:  sw_rdata = stat_q;
    endcase
  end

  a_r3_empty_reads_none: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (best_q == NONE_PRIO));
  a_r4_line_tracks_compare: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (best_q < cur_q));
  a_r6_ack_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_out) |=> (cur_q == $past(best_q)));
  a_r6_ack_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_out) |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));
  a_r7_idle_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |=> ($stable(cur_q) && $stable(pend_q)));
  a_r10_user_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && view == VIEW_USER && !notif_valid && !ack_rd) |=> ($stable(cur_q) && $stable(pend_q)));
  a_r5_rsvd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (notif_valid && notif_ready && notif_prio == RSVD_PRIO && !sw_wr) |=> $stable(pend_q));
endmodule

// File: tb/thread_irq_ctx_tb.sv
module thread_irq_ctx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        notif_valid = 1'b0;
  logic        notif_ready;
  logic [2:0]  notif_prio = '0;
  logic        sw_wr = 1'b0;
  logic [PS+1:0] sw_addr = '0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sw_rdata;
  logic        ack_rd = 1'b0;
  logic [15:0] ack_data;
  logic        irq_out;

  int total = 0;
  int fails = 0;

  // reference state
  bit [7:0] m_pend = 8'h00;
  int       m_cur  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_irq_ctx #(.NPRIO(8), .PAGE_SHIFT(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .notif_valid(notif_valid), .notif_ready(notif_ready),
    .notif_prio(notif_prio), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .ack_rd(ack_rd), .ack_data(ack_data), .irq_out(irq_out)
  );

  function automatic int m_best(bit [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 255;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, bit nv, int np, bit wr, int view, int ofs, int wd, bit ack);
    int  mb, exp_rd;
    bit  mexc;
    notif_valid = nv; notif_prio = np[2:0]; sw_wr = wr;
    sw_addr = {view[1:0], {(PS-2){1'b0}}, ofs[1:0]};
    sw_wdata = wd[7:0]; ack_rd = ack;
    #1;
    mb = m_best(m_pend);
    mexc = (mb < m_cur);
    check("R4", int'(irq_out), int'(mexc));
    check("R11", int'(notif_ready), int'(!ack));
    case (ofs)
      0: exp_rd = m_cur;
      1: exp_rd = int'(m_pend);
      2: exp_rd = mb;
      default: exp_rd = mexc ? 128 : 0;
    endcase
    check(tag, int'(sw_rdata), exp_rd);
    if (ack) check(tag, int'(ack_data), ((mexc ? 128 : 0) << 8) | (mexc ? mb : m_cur));
    @(posedge clk);
    if (ack) begin
      if (mexc) begin
        m_cur = mb;
        m_pend[mb] = 1'b0;
      end
    end else begin
      if (wr) begin
        if (view <= 1) begin
          if (ofs == 0) m_cur = wd & 255;
          if (ofs == 1) m_pend = wd[7:0];
        end else if (view == 2 && ofs == 0 && ((wd & 255) < 7 || (wd & 255) == 255)) begin
          m_cur = wd & 255;
        end
      end
      if (nv && np != 7) m_pend[np] = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state through every offset
    for (int o = 0; o < 4; o++) cyc("R1", 0, 0, 0, 0, o, 0, 0);
    // R8 physical view opens the mask
    cyc("R8", 0, 0, 1, 0, 0, 255, 0);
    // R2 notification sets bit 5
    cyc("R2", 1, 5, 0, 0, 1, 0, 0);
    cyc("R2", 0, 0, 0, 0, 1, 0, 0);
    // R3 best of several
    cyc("R3", 1, 6, 0, 0, 2, 0, 0);
    cyc("R3", 1, 2, 0, 0, 2, 0, 0);
    cyc("R3", 0, 0, 0, 0, 2, 0, 0);
    // R6 acknowledge with line high
    cyc("R6", 0, 0, 0, 0, 0, 0, 1);
    cyc("R6", 0, 0, 0, 0, 1, 0, 0);
    // R7 acknowledge with line low
    cyc("R7", 0, 0, 0, 0, 0, 0, 1);
    cyc("R7", 0, 0, 0, 0, 1, 0, 0);
    // R9 OS view: reserved value and pending write ignored, 6 accepted
    cyc("R9", 0, 0, 1, 2, 0, 7, 0);
    cyc("R9", 0, 0, 1, 2, 1, 255, 0);
    cyc("R9", 0, 0, 1, 2, 0, 6, 0);
    cyc("R9", 0, 0, 0, 2, 3, 0, 0);
    // R4 equal priorities keep line low
    cyc("R4", 0, 0, 1, 1, 0, 5, 0);
    cyc("R4", 0, 0, 0, 1, 3, 0, 0);
    // R10 user view writes ignored
    cyc("R10", 0, 0, 1, 3, 0, 255, 0);
    cyc("R10", 0, 0, 1, 3, 1, 0, 0);
    cyc("R10", 0, 0, 0, 3, 0, 0, 0);
    cyc("R10", 0, 0, 0, 3, 1, 0, 0);
    // R5 reserved priority dropped
    cyc("R5", 1, 7, 0, 0, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0, 1, 0, 0);
    // R11 notification and write blocked during acknowledge
    cyc("R11", 0, 0, 1, 0, 0, 255, 0);
    cyc("R11", 1, 0, 1, 0, 0, 3, 1);
    cyc("R11", 0, 0, 0, 0, 1, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0);
    // R3 emptied vector reads 0xFF
    cyc("R3", 0, 0, 1, 1, 1, 0, 0);
    cyc("R3", 0, 0, 0, 1, 2, 0, 0);
    // R8 replace merged with same-cycle notification
    cyc("R8", 1, 1, 1, 0, 1, 8'h40, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0, 0);
    // R12 mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc("R12", $urandom_range(0, 1) == 1, int'($urandom_range(0, 7)),
          r < 25, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          (r < 5) ? 255 : int'($urandom_range(0, 9)), r >= 85);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule